// File: doc/BRIEF.md
# USB Endpoint Stall and Buffer-Status Controller

This block holds the per-endpoint status for a full-speed USB device controller with sixteen endpoint slots. Slot 0 is the control OUT endpoint, slot 1 is the control IN endpoint, and slots 2 to 15 are the general endpoints 1 to 14. For every slot it keeps these flags:

- a halt (stall) flag
- two buffer-full flags
- the next data PID
- a setup-present flag and a setup-overwritten flag
- the buffer the CPU currently owns
- the buffer the USB side uses next (internal, not readable)

A microprocessor sends one-byte command codes with no data phase. These codes halt an endpoint, release it, or mark an IN buffer as ready to send. The USB serial engine reports events, each naming a slot and a kind. The kinds are SETUP token, setup write finished, IN acknowledged, OUT received, NAK and error.

The CPU picks a slot with `status_ep` and reads that slot's status byte combinationally. A one-cycle `status_rd` pulse marks the read as consumed. If the slot's setup write is not in progress, this clears its overwrite flag at the next clock edge. When a command and an event reach the same slot in one cycle, the event is applied first and the command second, so the command wins. The `DBL_MASK` parameter chooses which slots are double-buffered. By default these are slots 2 to 15.

Top module: `usb_ep_status_ctrl`

## Requirements
- R1: After reset, the status byte of every slot reads 0x00, and bit 0 of the status byte always reads 0.
- R2: Command 0x40+n sets bit 7 (halted) of slot n and clears bit 2 (setup present) of slot n.
- R3: Command 0x80+n clears bit 7 of slot n and re-initialises it. Bits 6, 5 and 2 (buffers) are cleared, bit 4 (data PID) goes to 0 (DATA0), and bit 1 (CPU buffer) and the USB-side buffer pointer go back to the primary buffer.
- R4: An event of kind 1 (SETUP token) on a halted control slot (0 or 1) clears its halt flag with the same re-initialisation as R3. A later 0x40+n command halts the slot again. A SETUP event on slots 2 to 15 has no effect.
- R5: Command 0x61 to 0x6F (slot = low nibble, 1 to 15) sets the full flag of the buffer the CPU owns, which is bit 5 when bit 1 is 0 and bit 6 when bit 1 is 1. On a double-buffered slot the command also toggles bit 1.
- R6: On a single-buffered slot, bit 1 and bit 6 always read 0.
- R7: Bit 4 toggles on an event of kind 3 (IN acknowledged) or kind 4 (OUT received) on a slot that is not halted. It is unchanged by kind 5 (NAK), by kind 6 (error), and by any event on a halted slot.
- R8: Kind 3 clears the full flag of the USB-side buffer, and kind 4 sets it. On a double-buffered slot the USB-side buffer alternates primary, secondary, primary after each such event.
- R9: Kind 2 (setup write finished) on a control slot sets bit 2. A SETUP token that arrives while bit 2 is set also sets bit 3 (setup overwritten).
- R10: A `status_rd` pulse clears bit 3 of the selected slot at the next edge, but only when no setup write is in progress on that slot (a SETUP token seen and kind 2 not yet seen). Otherwise bit 3 stays set.
- R11: Command codes outside 0x40-0x4F, 0x61-0x6F and 0x80-0x8F are ignored and leave every slot's status unchanged. The ignored codes include 0x60 and the 0x5n, 0x7n, 0x9n and 0xCn codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_code | input | 8 | Command code |
| evt_valid | input | 1 | Serial-engine event present this cycle |
| evt_ep | input | 4 | Slot the event concerns |
| evt_kind | input | 3 | Event kind: 1 SETUP, 2 setup done, 3 IN ack, 4 OUT ok, 5 NAK, 6 error |
| status_rd | input | 1 | Read-consume pulse for the selected slot |
| status_ep | input | 4 | Slot whose status is shown |
| status_byte | output | 8 | Status of the selected slot |

## Verification
Command and event sequences are applied to a control slot, a single-buffered IN slot and double-buffered general slots, so that single- and double-buffer behaviour can be told apart by bits 1, 5 and 6.

Further sequences isolate specific behaviours:
- Toggle sequences interleave NAK, error and halted-slot events with good transfers, which separates toggling from holding.
- A SETUP token is given both to a halted control slot and to a halted general slot, which separates the automatic release from an ignored event.
- The overwrite sequence reads the status once during a setup write and once after it, which checks that the clear is gated.
- A set of undefined codes, including 0x60, is issued around known state to show that none of them has any effect.

// File: rtl/usb_ep_status_pkg.sv
// Package: shared event encoding and per-slot state record for the
// endpoint status controller.
package usb_ep_status_pkg;

    // Serial-engine event kinds.
    typedef enum logic [2:0] {
        EV_NONE       = 3'd0,
        EV_SETUP      = 3'd1,
        EV_SETUP_DONE = 3'd2,
        EV_IN_ACK     = 3'd3,
        EV_OUT_OK     = 3'd4,
        EV_NAK        = 3'd5,
        EV_ERR        = 3'd6,
        EV_RSVD       = 3'd7
    } ev_kind_e;

    // Stored state of one endpoint slot.
    typedef struct packed {
        logic halted;
        logic full_b;
        logic full_a;
        logic pid1;
        logic ovw;
        logic setup;
        logic cpu_sel;
        logic usb_sel;
        logic setup_busy;
    } slot_state_t;

    // Upper nibbles of the command groups.
    localparam logic [3:0] GRP_HALT    = 4'h4;
    localparam logic [3:0] GRP_READY   = 4'h6;
    localparam logic [3:0] GRP_RELEASE = 4'h8;

endpackage

// File: rtl/usb_ep_cmd_decode.sv
// Module: usb_ep_cmd_decode
// Splits a command byte into one of three operations plus a target slot.
// Assumes slots are addressed by the low nibble of the code; any code that
// falls outside the three groups produces no operation.
module usb_ep_cmd_decode
    import usb_ep_status_pkg::*;
#(
    parameter int NUM_EP = 16,
    localparam int EP_W  = $clog2(NUM_EP)
) (
    input  logic            valid,
    input  logic [7:0]      code,
    output logic            op_halt,
    output logic            op_release,
    output logic            op_ready,
    output logic [EP_W-1:0] slot
);

    logic in_range;

    // Decode the group nibble and range-check the slot field.
    always_comb begin
        in_range   = (32'(code[3:0]) < NUM_EP);
        slot       = EP_W'(code[3:0]);
        op_halt    = valid && in_range && (code[7:4] == GRP_HALT);
        op_release = valid && in_range && (code[7:4] == GRP_RELEASE);
        op_ready   = valid && in_range && (code[7:4] == GRP_READY)
                     && (code[3:0] != 4'h0);
    end

endmodule

// File: rtl/usb_ep_slot.sv
// Module: usb_ep_slot
// Holds and updates the status of one endpoint slot. Events are applied
// first, then commands, so a command in the same cycle takes precedence.
// IS_CTRL enables SETUP handling; DOUBLE enables the second buffer.
module usb_ep_slot
    import usb_ep_status_pkg::*;
#(
    parameter bit IS_CTRL = 1'b0,
    parameter bit DOUBLE  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_setup,
    input  logic       ev_setup_done,
    input  logic       ev_in_ack,
    input  logic       ev_out_ok,
    input  logic       rd_clear,
    input  logic       op_halt,
    input  logic       op_release,
    input  logic       op_ready,
    output logic [7:0] status
);

    slot_state_t q, n;

    // Returns the state with buffers flushed and toggle/pointers reset.
    function automatic slot_state_t reinit(input slot_state_t s);
        slot_state_t r;
        r         = s;
        r.halted  = 1'b0;
        r.full_a  = 1'b0;
        r.full_b  = 1'b0;
        r.pid1    = 1'b0;
        r.cpu_sel = 1'b0;
        r.usb_sel = 1'b0;
        r.setup   = 1'b0;
        return r;
    endfunction

    // Next-state computation: events on the old state, then commands.
    always_comb begin
        n = q;
        if (IS_CTRL && ev_setup) begin
            if (q.setup)  n.ovw = 1'b1;
            if (q.halted) n = reinit(n);
            n.setup_busy = 1'b1;
        end
        if (IS_CTRL && ev_setup_done) begin
            n.setup      = 1'b1;
            n.setup_busy = 1'b0;
        end
        if (ev_in_ack && !q.halted) begin
            if (DOUBLE && q.usb_sel) n.full_b = 1'b0;
            else                     n.full_a = 1'b0;
            n.pid1 = ~q.pid1;
            if (DOUBLE) n.usb_sel = ~q.usb_sel;
        end
        if (ev_out_ok && !q.halted) begin
            if (DOUBLE && q.usb_sel) n.full_b = 1'b1;
            else                     n.full_a = 1'b1;
            n.pid1 = ~q.pid1;
            if (DOUBLE) n.usb_sel = ~q.usb_sel;
        end
        if (rd_clear && !q.setup_busy) n.ovw = 1'b0;
        if (op_halt) begin
            n.halted = 1'b1;
            n.setup  = 1'b0;
        end
        if (op_release) n = reinit(n);
        if (op_ready) begin
            if (DOUBLE && n.cpu_sel) n.full_b = 1'b1;
            else                     n.full_a = 1'b1;
            if (DOUBLE) n.cpu_sel = ~n.cpu_sel;
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    // Assemble the readable status byte.
    always_comb begin
        status = {q.halted, q.full_b & DOUBLE, q.full_a, q.pid1,
                  q.ovw, q.setup, q.cpu_sel & DOUBLE, 1'b0};
    end

endmodule

// File: rtl/usb_ep_status_ctrl.sv
// Module: usb_ep_status_ctrl
// Top level: decodes CPU commands and serial-engine events into per-slot
// strobes, instantiates one state slot per endpoint and muxes the status of
// the selected slot. Slots 0 and 1 are the control pair; DBL_MASK chooses
// the double-buffered slots.
module usb_ep_status_ctrl
    import usb_ep_status_pkg::*;
#(
    parameter int              NUM_EP   = 16,
    parameter logic [15:0]     DBL_MASK = 16'hFFFC,
    localparam int             EP_W     = $clog2(NUM_EP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [7:0]      cmd_code,
    input  logic            evt_valid,
    input  logic [EP_W-1:0] evt_ep,
    input  logic [2:0]      evt_kind,
    input  logic            status_rd,
    input  logic [EP_W-1:0] status_ep,
    output logic [7:0]      status_byte
);

    logic            op_halt, op_release, op_ready;
    logic [EP_W-1:0] op_slot;
    ev_kind_e        kind;
    logic [7:0]      slot_stat [NUM_EP];

    usb_ep_cmd_decode #(.NUM_EP(NUM_EP)) u_dec (
        .valid      (cmd_valid),
        .code       (cmd_code),
        .op_halt    (op_halt),
        .op_release (op_release),
        .op_ready   (op_ready),
        .slot       (op_slot)
    );

    // Interpret the raw event kind.
    always_comb kind = ev_kind_e'(evt_kind);

    for (genvar i = 0; i < NUM_EP; i++) begin : g_slot
        logic hit_ev, hit_op;
        // Per-slot address match for events and commands.
        always_comb begin
            hit_ev = evt_valid && (evt_ep == EP_W'(i));
            hit_op = (op_slot == EP_W'(i));
        end
        usb_ep_slot #(
            .IS_CTRL (i < 2),
            .DOUBLE  (DBL_MASK[i])
        ) u_slot (
            .clk           (clk),
            .rst_n         (rst_n),
            .ev_setup      (hit_ev && kind == EV_SETUP),
            .ev_setup_done (hit_ev && kind == EV_SETUP_DONE),
            .ev_in_ack     (hit_ev && kind == EV_IN_ACK),
            .ev_out_ok     (hit_ev && kind == EV_OUT_OK),
            .rd_clear      (status_rd && status_ep == EP_W'(i)),
            .op_halt       (op_halt && hit_op),
            .op_release    (op_release && hit_op),
            .op_ready      (op_ready && hit_op),
            .status        (slot_stat[i])
        );
    end

    // Read mux for the selected slot.
    always_comb status_byte = slot_stat[status_ep];

endmodule

// File: rtl/usb_ep_status_chk.sv
// Module: usb_ep_status_chk
// Port-level properties of the endpoint status controller, bound to the top.
module usb_ep_status_chk #(
    parameter int          NUM_EP   = 16,
    parameter logic [15:0] DBL_MASK = 16'hFFFC,
    localparam int         EP_W     = $clog2(NUM_EP)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [7:0]      cmd_code,
    input logic            evt_valid,
    input logic [EP_W-1:0] evt_ep,
    input logic [2:0]      evt_kind,
    input logic            status_rd,
    input logic [EP_W-1:0] status_ep,
    input logic [7:0]      status_byte
);

    logic bad_code;
    always_comb bad_code = !(cmd_code[7:4] == 4'h4 || cmd_code[7:4] == 4'h8 ||
                             (cmd_code[7:4] == 4'h6 && cmd_code[3:0] != 4'h0));

    // R2
    halt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code[7:4] == 4'h4 && status_ep == EP_W'(cmd_code[3:0]))
        |=> (status_ep != $past(status_ep) || status_byte[7]));

    // R3
    release_reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code[7:4] == 4'h8 && status_ep == EP_W'(cmd_code[3:0]))
        |=> (status_ep != $past(status_ep) ||
             (status_byte[7:4] == 4'h0 && !status_byte[2] && !status_byte[1])));

    // R6
    single_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !DBL_MASK[status_ep] |-> (!status_byte[1] && !status_byte[6]));

    // R7
    nak_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_kind == 3'd5 || evt_kind == 3'd6) && !cmd_valid && !status_rd)
        |=> (status_ep != $past(status_ep) || $stable(status_byte)));

    // R11
    bad_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && bad_code && !evt_valid && !status_rd)
        |=> (status_ep != $past(status_ep) || $stable(status_byte)));

endmodule

bind usb_ep_status_ctrl usb_ep_status_chk #(
    .NUM_EP   (NUM_EP),
    .DBL_MASK (DBL_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .evt_valid   (evt_valid),
    .evt_ep      (evt_ep),
    .evt_kind    (evt_kind),
    .status_rd   (status_rd),
    .status_ep   (status_ep),
    .status_byte (status_byte)
);

// File: tb/usb_ep_status_ctrl_test.sv
// Directed bench for usb_ep_status_ctrl: one task per scenario.
module usb_ep_status_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = '0;
    logic       evt_valid = 1'b0;
    logic [3:0] evt_ep = '0;
    logic [2:0] evt_kind = '0;
    logic       status_rd = 1'b0;
    logic [3:0] status_ep = '0;
    logic [7:0] status_byte;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    usb_ep_status_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .evt_valid(evt_valid), .evt_ep(evt_ep), .evt_kind(evt_kind),
        .status_rd(status_rd), .status_ep(status_ep), .status_byte(status_byte)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] c);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic evt(input logic [3:0] ep, input logic [2:0] k);
        @(negedge clk); evt_valid = 1'b1; evt_ep = ep; evt_kind = k;
        @(negedge clk); evt_valid = 1'b0;
    endtask

    task automatic expect_slot(input string req, input logic [3:0] ep, input logic [7:0] exp);
        @(negedge clk); status_ep = ep; #1;
        check(req, status_byte, exp);
    endtask

    task automatic consume(input logic [3:0] ep);
        @(negedge clk); status_ep = ep; status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 16; i++) expect_slot("R1 reset", 4'(i), 8'h00);
    endtask

    task automatic t_halt_release();
        cmd(8'h65);        expect_slot("R5 ready dbl", 4'd5, 8'h22);
        evt(4'd5, 3'd4);   expect_slot("R8 out ok", 4'd5, 8'h32);
        cmd(8'h45);        expect_slot("R2 halt", 4'd5, 8'hB2);
        cmd(8'h85);        expect_slot("R3 release", 4'd5, 8'h00);
    endtask

    task automatic t_setup_release();
        cmd(8'h40);        expect_slot("R2 halt ctrl", 4'd0, 8'h80);
        evt(4'd0, 3'd1);   expect_slot("R4 setup release", 4'd0, 8'h00);
        evt(4'd0, 3'd2);   expect_slot("R9 setup present", 4'd0, 8'h04);
        cmd(8'h40);        expect_slot("R4 re-halt", 4'd0, 8'h80);
        cmd(8'h47);
        evt(4'd7, 3'd1);   expect_slot("R4 non-ctrl setup ignored", 4'd7, 8'h80);
    endtask

    task automatic t_overwrite();
        cmd(8'h80);        expect_slot("R3 release ctrl", 4'd0, 8'h00);
        evt(4'd0, 3'd1);
        evt(4'd0, 3'd2);   expect_slot("R9 stored", 4'd0, 8'h04);
        evt(4'd0, 3'd1);   expect_slot("R9 overwrite", 4'd0, 8'h0C);
        consume(4'd0);     expect_slot("R10 busy keeps flag", 4'd0, 8'h0C);
        evt(4'd0, 3'd2);   expect_slot("R10 done", 4'd0, 8'h0C);
        consume(4'd0);     expect_slot("R10 read clears", 4'd0, 8'h04);
    endtask

    task automatic t_ready();
        cmd(8'h61);        expect_slot("R5 ready single", 4'd1, 8'h20);
        cmd(8'h61);        expect_slot("R6 single keeps sel", 4'd1, 8'h20);
        evt(4'd1, 3'd3);   expect_slot("R8 in ack single", 4'd1, 8'h10);
        cmd(8'h69);        expect_slot("R5 first buffer", 4'd9, 8'h22);
        cmd(8'h69);        expect_slot("R5 second buffer", 4'd9, 8'h60);
        evt(4'd9, 3'd3);   expect_slot("R8 ack primary", 4'd9, 8'h50);
        evt(4'd9, 3'd3);   expect_slot("R8 ack secondary", 4'd9, 8'h00);
    endtask

    task automatic t_toggle();
        evt(4'd3, 3'd4);   expect_slot("R7 toggle", 4'd3, 8'h30);
        evt(4'd3, 3'd5);   expect_slot("R7 nak hold", 4'd3, 8'h30);
        evt(4'd3, 3'd6);   expect_slot("R7 err hold", 4'd3, 8'h30);
        evt(4'd3, 3'd4);   expect_slot("R8 second out", 4'd3, 8'h60);
        cmd(8'h43);
        evt(4'd3, 3'd4);   expect_slot("R7 halted hold", 4'd3, 8'hE0);
    endtask

    task automatic t_ignored();
        logic [7:0] codes [6] = '{8'h60, 8'h00, 8'h52, 8'h92, 8'hC2, 8'h72};
        cmd(8'h62);        expect_slot("R5 slot2", 4'd2, 8'h22);
        foreach (codes[i]) begin
            cmd(codes[i]);
            expect_slot("R11 slot2 unchanged", 4'd2, 8'h22);
            expect_slot("R11 slot0 unchanged", 4'd0, 8'h04);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_halt_release();
        t_setup_release();
        t_overwrite();
        t_ready();
        t_toggle();
        t_ignored();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule